// File: doc/BRIEF.md
# Single-Cycle Seven-Instruction Processor Core

This block is a 32-bit processor core that completes each instruction in one clock cycle. It supports a fixed subset of seven instructions: register add, register subtract, OR with an immediate, word load, word store, branch on equal and an absolute jump. The program counter, the instruction decoder, a 32-entry register file, the immediate extender, a three-function ALU and the writeback and destination selection are all inside the block.

The core fetches from a word-organised instruction memory, using the byte-aligned program counter as the address. It reaches a data memory through an address, write data, write enable and a combinational read data input. Register reads, the ALU and the next-PC selection settle within the cycle. Register-file writes, memory writes and the PC update take effect on the rising clock edge. Any opcode outside the subset, and any R-type function code other than add or subtract, runs as a no-op.

Top module: `mcc_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears every register to 0.
- R2: An R-type word (opcode 000000) with function code 100000 writes rs + rt into register rd (rs in bits 25:21, rt in 20:16, rd in 15:11).
- R3: An R-type word with function code 100010 writes rs - rt into register rd, modulo 2^32.
- R4: Opcode 001101 writes rs OR the zero-extended 16-bit immediate (bits 15:0) into register rt.
- R5: Opcode 100011 loads the data word at address rs + sign-extended immediate into register rt.
- R6: Opcode 101011 drives address rs + sign-extended immediate and data rt, and asserts the data write enable. No other instruction asserts the write enable.
- R7: Opcode 000100 compares rs with rt by subtraction. When they are equal the next PC is PC + 4 + (sign-extended immediate << 2); otherwise it is PC + 4.
- R8: Opcode 000010 sets the next PC to {upper 4 bits of PC + 4, target bits 25:0, 2'b00}.
- R9: Register 0 always reads as 0, and writes addressed to it are discarded.
- R10: An unknown opcode, or an R-type word with any other function code, writes no register, writes no memory and advances the PC by 4.
- R11: Every instruction other than a branch or a jump advances the PC by 4, and the PC stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr_o | output | 32 | Byte address of the current instruction (the PC) |
| imem_data_i | input | 32 | Instruction word at imem_addr_o |
| dmem_addr_o | output | 32 | Data memory byte address (ALU result) |
| dmem_wdata_o | output | 32 | Store data (register rt value) |
| dmem_we_o | output | 1 | Data memory write enable, sampled at the rising edge |
| dmem_rdata_i | input | 32 | Data word read combinationally at dmem_addr_o |

## Verification
The register file can be seen only through stores, so every check of arithmetic, register 0, a skipped instruction or the reset clear is written as a short program that ends by storing the result, followed by a jump or branch to itself. The hardest cases to reach are the ones that must leave no trace: a taken branch that skips a store, an unknown opcode next to a write into r0, and a register value left over from a previous program. Each of these is placed directly before a store of the register it could have changed, and the data memory is seeded with a marker value so that any missing or extra write shows up. Negative load and store offsets and a backward branch to itself exercise sign extension in both the address path and the branch-target path.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

    localparam logic [5:0] OP_RTYPE = 6'b000000;
    localparam logic [5:0] OP_ORI   = 6'b001101;
    localparam logic [5:0] OP_LW    = 6'b100011;
    localparam logic [5:0] OP_SW    = 6'b101011;
    localparam logic [5:0] OP_BEQ   = 6'b000100;
    localparam logic [5:0] OP_J     = 6'b000010;

    localparam logic [5:0] FN_ADD   = 6'b100000;
    localparam logic [5:0] FN_SUB   = 6'b100010;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00,
        ALU_SUB = 2'b01,
        ALU_OR  = 2'b10
    } alu_op_e;

    typedef struct packed {
        logic    reg_we;     // write register file
        logic    dst_is_rd;  // destination rd (1) or rt (0)
        logic    src_imm;    // ALU operand B from extended immediate
        logic    imm_signed; // sign (1) or zero (0) extension
        logic    load_sel;   // writeback from data memory
        logic    mem_we;     // store
        logic    is_branch;  // conditional on equal
        logic    is_jump;    // absolute jump
        alu_op_e alu_op;
    } ctrl_t;

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
    import mcc_pkg::*;
(
    input  logic [5:0] op_i,
    input  logic [5:0] funct_i,
    output ctrl_t      ctrl_o
);

    always_comb begin
        ctrl_o = '0;
        ctrl_o.alu_op = ALU_ADD;
        unique case (op_i)
            OP_RTYPE: begin
                ctrl_o.dst_is_rd = 1'b1;
                if (funct_i == FN_ADD) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu_op = ALU_ADD;
                end else if (funct_i == FN_SUB) begin
                    ctrl_o.reg_we = 1'b1;
                    ctrl_o.alu_op = ALU_SUB;
                end
            end
            OP_ORI: begin
                ctrl_o.reg_we  = 1'b1;
                ctrl_o.src_imm = 1'b1;
                ctrl_o.alu_op  = ALU_OR;
            end
            OP_LW: begin
                ctrl_o.reg_we     = 1'b1;
                ctrl_o.src_imm    = 1'b1;
                ctrl_o.imm_signed = 1'b1;
                ctrl_o.load_sel   = 1'b1;
            end
            OP_SW: begin
                ctrl_o.src_imm    = 1'b1;
                ctrl_o.imm_signed = 1'b1;
                ctrl_o.mem_we     = 1'b1;
            end
            OP_BEQ: begin
                ctrl_o.is_branch = 1'b1;
                ctrl_o.alu_op    = ALU_SUB;
            end
            OP_J: begin
                ctrl_o.is_jump = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mcc_alu.sv
module mcc_alu
    import mcc_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  alu_op_e         op_i,
    output logic [XLEN-1:0] y_o,
    output logic            zero_o
);

    always_comb begin
        unique case (op_i)
            ALU_SUB: y_o = a_i - b_i;
            ALU_OR:  y_o = a_i | b_i;
            default: y_o = a_i + b_i;
        endcase
        zero_o = (y_o == '0);
    end

endmodule

// File: rtl/mcc_regfile.sv
module mcc_regfile #(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32,
    localparam int unsigned AW   = $clog2(NREGS)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   ra_addr_i,
    input  logic [AW-1:0]   rb_addr_i,
    input  logic            we_i,
    input  logic [AW-1:0]   w_addr_i,
    input  logic [XLEN-1:0] w_data_i,
    output logic [XLEN-1:0] ra_data_o,
    output logic [XLEN-1:0] rb_data_o
);

    logic [XLEN-1:0] regs_d [NREGS];
    logic [XLEN-1:0] regs_q [NREGS];

    always_comb begin
        for (int i = 0; i < NREGS; i++) begin
            regs_d[i] = rst ? '0 : regs_q[i];
        end
        if (!rst && we_i && (w_addr_i != '0)) begin
            regs_d[w_addr_i] = w_data_i;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign ra_data_o = (ra_addr_i == '0) ? '0 : regs_q[ra_addr_i];
    assign rb_data_o = (rb_addr_i == '0) ? '0 : regs_q[rb_addr_i];

endmodule

// File: rtl/mcc_core.sv
module mcc_core
    import mcc_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32
) (
    input  logic            clk,
    input  logic            rst,
    output logic [XLEN-1:0] imem_addr_o,
    input  logic [XLEN-1:0] imem_data_i,
    output logic [XLEN-1:0] dmem_addr_o,
    output logic [XLEN-1:0] dmem_wdata_o,
    output logic            dmem_we_o,
    input  logic [XLEN-1:0] dmem_rdata_i
);

    localparam int unsigned AW     = $clog2(NREGS);
    localparam int unsigned IMM_W  = 16;
    localparam int unsigned TGT_W  = 26;
    localparam int unsigned PC_HI  = XLEN - TGT_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_state_t;

    core_state_t st_d, st_q;

    // instruction fields
    logic [5:0]       op;
    logic [5:0]       funct;
    logic [AW-1:0]    rs_idx, rt_idx, rd_idx;
    logic [IMM_W-1:0] imm;
    logic [TGT_W-1:0] target;

    assign op     = imem_data_i[31:26];
    assign rs_idx = imem_data_i[21 +: AW];
    assign rt_idx = imem_data_i[16 +: AW];
    assign rd_idx = imem_data_i[11 +: AW];
    assign funct  = imem_data_i[5:0];
    assign imm    = imem_data_i[IMM_W-1:0];
    assign target = imem_data_i[TGT_W-1:0];

    ctrl_t           ctrl;
    logic [XLEN-1:0] rs_val, rt_val;
    logic [XLEN-1:0] imm_ext, imm_sext;
    logic [XLEN-1:0] alu_b, alu_y;
    logic            alu_zero;
    logic [XLEN-1:0] wb_data;
    logic [AW-1:0]   wb_addr;

    mcc_decode u_decode (
        .op_i    (op),
        .funct_i (funct),
        .ctrl_o  (ctrl)
    );

    mcc_regfile #(
        .XLEN  (XLEN),
        .NREGS (NREGS)
    ) u_regfile (
        .clk       (clk),
        .rst       (rst),
        .ra_addr_i (rs_idx),
        .rb_addr_i (rt_idx),
        .we_i      (ctrl.reg_we),
        .w_addr_i  (wb_addr),
        .w_data_i  (wb_data),
        .ra_data_o (rs_val),
        .rb_data_o (rt_val)
    );

    mcc_alu #(
        .XLEN (XLEN)
    ) u_alu (
        .a_i    (rs_val),
        .b_i    (alu_b),
        .op_i   (ctrl.alu_op),
        .y_o    (alu_y),
        .zero_o (alu_zero)
    );

    // extender, operand and writeback selection
    always_comb begin
        imm_sext = {{(XLEN-IMM_W){imm[IMM_W-1]}}, imm};
        imm_ext  = ctrl.imm_signed ? imm_sext : {{(XLEN-IMM_W){1'b0}}, imm};
        alu_b    = ctrl.src_imm ? imm_ext : rt_val;
        wb_data  = ctrl.load_sel ? dmem_rdata_i : alu_y;
        wb_addr  = ctrl.dst_is_rd ? rd_idx : rt_idx;
    end

    // next program counter
    logic [XLEN-1:0] pc_seq, pc_branch, pc_jump;

    always_comb begin
        pc_seq    = st_q.pc + XLEN'(4);
        pc_branch = pc_seq + {imm_sext[XLEN-3:0], 2'b00};
        pc_jump   = {pc_seq[XLEN-1 -: PC_HI], target, 2'b00};

        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else if (ctrl.is_jump) begin
            st_d.pc = pc_jump;
        end else if (ctrl.is_branch && alu_zero) begin
            st_d.pc = pc_branch;
        end else begin
            st_d.pc = pc_seq;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign imem_addr_o  = st_q.pc;
    assign dmem_addr_o  = alu_y;
    assign dmem_wdata_o = rt_val;
    assign dmem_we_o    = ctrl.mem_we;

endmodule

// File: rtl/mcc_core_chk.sv
module mcc_core_chk #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst,
    input logic [XLEN-1:0] imem_addr_o,
    input logic [XLEN-1:0] imem_data_i,
    input logic            dmem_we_o
);

    localparam logic [5:0] C_SW  = 6'b101011;
    localparam logic [5:0] C_BEQ = 6'b000100;
    localparam logic [5:0] C_J   = 6'b000010;

    logic [5:0]      opc;
    logic [XLEN-1:0] seq_pc, br_pc, jmp_pc;
    logic            rst_seen;

    assign opc    = imem_data_i[31:26];
    assign seq_pc = imem_addr_o + XLEN'(4);
    assign br_pc  = seq_pc + {{(XLEN-18){imem_data_i[15]}}, imem_data_i[15:0], 2'b00};
    assign jmp_pc = {seq_pc[XLEN-1:28], imem_data_i[25:0], 2'b00};

    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            AST_PC_CLEARED: assert (imem_addr_o == '0); // R1
        end
    end

    AST_STORE_ONLY_WE: assert property (@(posedge clk) disable iff (rst)
        dmem_we_o |-> (opc == C_SW)); // R6

    AST_PC_STEP_SEQ: assert property (@(posedge clk) disable iff (rst)
        !(opc == C_BEQ || opc == C_J) |=> (imem_addr_o == $past(seq_pc))); // R11

    AST_JUMP_DEST: assert property (@(posedge clk) disable iff (rst)
        (opc == C_J) |=> (imem_addr_o == $past(jmp_pc))); // R8

    AST_BEQ_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        (opc == C_BEQ) |=> (imem_addr_o == $past(seq_pc) || imem_addr_o == $past(br_pc))); // R7

    AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rst)
        imem_addr_o[1:0] == 2'b00); // R11

endmodule

bind mcc_core mcc_core_chk #(.XLEN(XLEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .imem_addr_o (imem_addr_o),
    .imem_data_i (imem_data_i),
    .dmem_we_o   (dmem_we_o)
);

// File: tb/mcc_core_test.sv
module mcc_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_data;
    logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem      [MEM_WORDS];
    logic [31:0] dmem      [MEM_WORDS];
    logic [31:0] dmem_seed [MEM_WORDS];
    int          wr_count;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mcc_core uut (
        .clk          (clk),
        .rst          (rst),
        .imem_addr_o  (imem_addr),
        .imem_data_i  (imem_data),
        .dmem_addr_o  (dmem_addr),
        .dmem_wdata_o (dmem_wdata),
        .dmem_we_o    (dmem_we),
        .dmem_rdata_i (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < MEM_WORDS; i++) dmem[i] <= dmem_seed[i];
            wr_count <= 0;
        end else if (dmem_we) begin
            dmem[dmem_addr[7:2]] <= dmem_wdata;
            wr_count <= wr_count + 1;
        end
    end

    // encoders
    function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] im);
        return {op, 5'(rs), 5'(rt), im};
    endfunction
    function automatic logic [31:0] enc_j(input int word_idx);
        return {6'b000010, 26'(word_idx)};
    endfunction

    localparam logic [5:0] ORI = 6'b001101, LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;
    localparam logic [5:0] FADD = 6'b100000, FSUB = 6'b100010;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    endtask

    task automatic clear_mems();
        for (int i = 0; i < MEM_WORDS; i++) begin
            imem[i]      = 32'h0000_0000;
            dmem_seed[i] = 32'hFFFF_FFFF;
        end
    endtask

    // hold reset for two edges, release, then execute n instructions
    task automatic run_prog(input int n);
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        @(negedge clk) rst = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic t_alu();
        clear_mems();
        imem[0] = enc_i(ORI, 0, 1, 16'h1234);
        imem[1] = enc_i(ORI, 0, 2, 16'hF000);
        imem[2] = enc_r(1, 2, 3, FADD);
        imem[3] = enc_r(1, 2, 4, FSUB);
        imem[4] = enc_i(SW, 0, 3, 16'h0000);
        imem[5] = enc_i(SW, 0, 4, 16'h0004);
        imem[6] = enc_i(SW, 0, 2, 16'h0008);
        imem[7] = enc_j(7);
        run_prog(12);
        check("R2 add", dmem[0], 32'h0001_0234);
        check("R3 sub wraps", dmem[1], 32'hFFFF_2234);
        check("R4 ori zero-extend", dmem[2], 32'h0000_F000);
        check("R8 jump to self", imem_addr, 32'd28);
    endtask

    task automatic t_reset();
        // registers still hold values from the previous program
        @(negedge clk) rst = 1'b1;
        @(negedge clk);
        check("R1 pc reset", imem_addr, 32'd0);
        clear_mems();
        imem[0] = enc_i(SW, 0, 3, 16'h0000);
        imem[1] = enc_i(SW, 0, 4, 16'h0004);
        imem[2] = enc_j(2);
        run_prog(5);
        check("R1 reg r3 cleared", dmem[0], 32'h0);
        check("R1 reg r4 cleared", dmem[1], 32'h0);
    endtask

    task automatic t_r0_unknown();
        clear_mems();
        imem[0] = enc_i(ORI, 0, 0, 16'h5555);
        imem[1] = enc_i(ORI, 0, 1, 16'h0077);
        imem[2] = 32'hFC21_FFFF;              // opcode 111111
        imem[3] = enc_r(0, 0, 1, 6'b000111);  // unknown function code
        imem[4] = enc_i(SW, 0, 0, 16'h0000);
        imem[5] = enc_i(SW, 0, 1, 16'h0004);
        imem[6] = enc_j(6);
        run_prog(10);
        check("R9 r0 reads zero", dmem[0], 32'h0);
        check("R10 r1 kept", dmem[1], 32'h0000_0077);
        check("R10 only stores write", 32'(wr_count), 32'd2);
        check("R11 pc stepped past no-ops", imem_addr, 32'd24);
    endtask

    task automatic t_load_store();
        clear_mems();
        dmem_seed[4] = 32'hCAFE_F00D;
        imem[0] = enc_i(ORI, 0, 1, 16'h0020);
        imem[1] = enc_i(LW, 1, 2, 16'hFFF0);
        imem[2] = enc_i(SW, 1, 2, 16'hFFE4);
        imem[3] = enc_i(LW, 0, 3, 16'h0010);
        imem[4] = enc_r(3, 2, 4, FADD);
        imem[5] = enc_i(SW, 0, 4, 16'h0008);
        imem[6] = enc_j(6);
        run_prog(10);
        check("R5 R6 negative offsets", dmem[1], 32'hCAFE_F00D);
        check("R5 load then add", dmem[2], 32'h95FD_E01A);
        check("R6 seed untouched", dmem[0], 32'hFFFF_FFFF);
    endtask

    task automatic t_branch();
        clear_mems();
        imem[0] = enc_i(ORI, 0, 1, 16'h0005);
        imem[1] = enc_i(ORI, 0, 2, 16'h0005);
        imem[2] = enc_i(BEQ, 1, 2, 16'h0002);
        imem[3] = enc_i(ORI, 0, 3, 16'h0BAD);
        imem[4] = enc_i(SW, 0, 3, 16'h0000);
        imem[5] = enc_i(BEQ, 1, 0, 16'h0005);
        imem[6] = enc_i(ORI, 0, 4, 16'h0011);
        imem[7] = enc_i(SW, 0, 4, 16'h0004);
        imem[8] = enc_i(BEQ, 0, 0, 16'hFFFF);
        run_prog(12);
        check("R7 taken branch skipped store", dmem[0], 32'hFFFF_FFFF);
        check("R7 not-taken falls through", dmem[1], 32'h0000_0011);
        check("R7 backward branch to self", imem_addr, 32'd32);
    endtask

    task automatic t_jump();
        clear_mems();
        imem[0] = enc_j(3);
        imem[1] = enc_i(ORI, 0, 1, 16'h0001);
        imem[2] = enc_i(SW, 0, 1, 16'h0000);
        imem[3] = enc_i(ORI, 0, 2, 16'h00AB);
        imem[4] = enc_i(SW, 0, 2, 16'h0004);
        imem[5] = enc_j(5);
        run_prog(8);
        check("R8 jump skipped store", dmem[0], 32'hFFFF_FFFF);
        check("R8 target reached", dmem[1], 32'h0000_00AB);
        check("R8 halt address", imem_addr, 32'd20);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        clear_mems();
        t_alu();
        t_reset();
        t_r0_unknown();
        t_load_store();
        t_branch();
        t_jump();
        finish_run();
    end

endmodule